// File: doc/BRIEF.md
# Per-Lane Predicate Register File

This block stores the predicate masks of one warp. It holds a set of registers, each one bit per thread lane. A predicate load/store or a branch test reads or writes a whole mask at once. A compare instruction writes the single bit that belongs to its own thread, and a predicated thread reads only its own bit.

There are four ports: a whole-mask read, a single-lane read, a whole-mask write and a single-lane write. Each is addressed by a register index. Reads are combinational. Writes take effect at the rising clock edge.

Register 0 leaves reset with every lane set, so code with no predicate runs on all lanes by default. A lane number at or above the warp width wraps back into range.

Top module: `pred_rf`

## Requirements
- R1: The file holds NREGS registers (default 32, index 5 bits), each LANES bits wide (default 32). The whole-mask read output equals the addressed register in the same cycle, combinationally.
- R2: While reset is asserted (rst_n low), register 0 reads as all ones and every other register reads as zero.
- R3: The single-lane read output equals bit `lane` of the addressed register, where `lane` is the thread number after wrapping.
- R4: A single-lane write sets or clears only bit `lane` of the addressed register at the next rising edge. All other bits of that register, and all other registers, are unchanged.
- R5: A thread number T with T >= LANES selects lane T mod LANES, for both single-lane read and single-lane write. With LANES = 32, thread 33 is lane 1 and thread 63 is lane 31.
- R6: A whole-mask write replaces the whole addressed register with the supplied value at the next rising edge.
- R7: When both writes address the same register in the same cycle, the result is the whole-mask value with the single-lane bit applied over it.
- R8: A read of a register that is being written in the current cycle returns the old contents. The new contents appear only after the rising edge.
- R9: With both write enables low, no register changes, whatever the write indices and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mrd_idx | input | IDX_W | Whole-mask read register index |
| mrd_data | output | LANES | Whole-mask read data |
| lrd_idx | input | IDX_W | Single-lane read register index |
| lrd_tid | input | TID_W | Single-lane read thread number |
| lrd_bit | output | 1 | Single-lane read bit |
| mwr_en | input | 1 | Whole-mask write enable |
| mwr_idx | input | IDX_W | Whole-mask write register index |
| mwr_data | input | LANES | Whole-mask write data |
| lwr_en | input | 1 | Single-lane write enable |
| lwr_idx | input | IDX_W | Single-lane write register index |
| lwr_tid | input | TID_W | Single-lane write thread number |
| lwr_bit | input | 1 | Single-lane write value |

## Verification
Read results are due in the same cycle as their inputs. The bench changes inputs on the falling edge and samples one time unit later, before any rising edge. Write results are due one rising edge after the write is presented. The bench first samples just before that edge to confirm the old value is still returned, then samples one time unit after the edge for the new value. A shadow array in the bench, updated by the stated rules, gives every expected value.

// File: rtl/pred_rf_pkg.sv
package pred_rf_pkg;
   localparam int DEF_LANES = 32;
   localparam int DEF_NREGS = 32;
   localparam int DEF_TID_W = 6;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/prf_lane_wrap.sv
module prf_lane_wrap #(
   parameter int LANES = pred_rf_pkg::DEF_LANES,
   parameter int TID_W = pred_rf_pkg::DEF_TID_W,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [TID_W-1:0] tid,
   output logic [LW-1:0]    lane
);
   if (pred_rf_pkg::is_pow2(LANES)) begin : g_mask
      assign lane = tid[LW-1:0];
   end else begin : g_mod
      logic [TID_W-1:0] rem;
      assign rem  = tid % TID_W'(LANES);
      assign lane = rem[LW-1:0];
   end
endmodule

// File: rtl/prf_lane_onehot.sv
module prf_lane_onehot #(
   parameter int LANES = pred_rf_pkg::DEF_LANES,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LW-1:0]    lane,
   output logic [LANES-1:0] sel
);
   for (genvar g = 0; g < LANES; g++) begin : g_sel
      assign sel[g] = (lane == LW'(g));
   end
endmodule

// File: rtl/prf_reg_cell.sv
module prf_reg_cell #(
   parameter int LANES    = pred_rf_pkg::DEF_LANES,
   parameter bit RST_ONES = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_hit,
   input  logic [LANES-1:0] mask_data,
   input  logic             lane_hit,
   input  logic [LANES-1:0] lane_sel,
   input  logic             lane_val,
   output logic [LANES-1:0] q
);
   logic [LANES-1:0] base;
   logic [LANES-1:0] nxt;

   always_comb begin
      base = mask_hit ? mask_data : q;
      if (lane_hit) nxt = (base & ~lane_sel) | (lane_sel & {LANES{lane_val}});
      else          nxt = base;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_ONES ? '1 : '0;
      else if (mask_hit || lane_hit) q <= nxt;
   end
endmodule

// File: rtl/pred_rf.sv
module pred_rf #(
   parameter int LANES = pred_rf_pkg::DEF_LANES,
   parameter int NREGS = pred_rf_pkg::DEF_NREGS,
   parameter int TID_W = pred_rf_pkg::DEF_TID_W,
   localparam int IDX_W = $clog2(NREGS),
   localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] mrd_idx,
   output logic [LANES-1:0] mrd_data,
   input  logic [IDX_W-1:0] lrd_idx,
   input  logic [TID_W-1:0] lrd_tid,
   output logic             lrd_bit,
   input  logic             mwr_en,
   input  logic [IDX_W-1:0] mwr_idx,
   input  logic [LANES-1:0] mwr_data,
   input  logic             lwr_en,
   input  logic [IDX_W-1:0] lwr_idx,
   input  logic [TID_W-1:0] lwr_tid,
   input  logic             lwr_bit
);
   if (LANES < 2) begin : g_bad_lanes
      $error("pred_rf: LANES must be at least 2");
   end
   if (NREGS < 2 || !pred_rf_pkg::is_pow2(NREGS)) begin : g_bad_regs
      $error("pred_rf: NREGS must be a power of two of at least 2");
   end
   if (TID_W < LW) begin : g_bad_tid
      $error("pred_rf: TID_W too narrow for LANES");
   end

   logic [LANES-1:0] regs [NREGS];
   logic [LW-1:0]    rd_lane;
   logic [LW-1:0]    wr_lane;
   logic [LANES-1:0] wr_sel;

   prf_lane_wrap #(.LANES(LANES), .TID_W(TID_W)) u_rd_wrap (.tid(lrd_tid), .lane(rd_lane));
   prf_lane_wrap #(.LANES(LANES), .TID_W(TID_W)) u_wr_wrap (.tid(lwr_tid), .lane(wr_lane));
   prf_lane_onehot #(.LANES(LANES)) u_wr_sel (.lane(wr_lane), .sel(wr_sel));

   for (genvar r = 0; r < NREGS; r++) begin : g_reg
      prf_reg_cell #(.LANES(LANES), .RST_ONES(r == 0)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .mask_hit  (mwr_en && (mwr_idx == IDX_W'(r))),
         .mask_data (mwr_data),
         .lane_hit  (lwr_en && (lwr_idx == IDX_W'(r))),
         .lane_sel  (wr_sel),
         .lane_val  (lwr_bit),
         .q         (regs[r])
      );
   end

   logic [LANES-1:0] lrd_word;
   assign mrd_data = regs[mrd_idx];
   assign lrd_word = regs[lrd_idx];
   assign lrd_bit  = lrd_word[rd_lane];
endmodule

// File: rtl/prf_chk.sv
module prf_chk #(
   parameter int LANES = 32,
   parameter int NREGS = 32,
   parameter int TID_W = 6,
   localparam int IDX_W = $clog2(NREGS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] mrd_idx,
   input logic [LANES-1:0] mrd_data,
   input logic             mwr_en,
   input logic [IDX_W-1:0] mwr_idx,
   input logic [LANES-1:0] mwr_data,
   input logic             lwr_en,
   input logic [IDX_W-1:0] lwr_idx,
   input logic [TID_W-1:0] lwr_tid,
   input logic             lwr_bit,
   input logic [LANES-1:0] regs [NREGS]
);
   logic seen_clk = 1'b0;
   always @(posedge clk) seen_clk <= 1'b1;

   always @(negedge clk) begin
      if (seen_clk && !rst_n) begin
         AST_RESET_VALUES: assert (regs[0] == '1 && regs[1] == '0); // R2
      end
   end

   AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mwr_en && !(lwr_en && lwr_idx == mwr_idx)) |=> regs[$past(mwr_idx)] == $past(mwr_data)); // R6

   AST_LANE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (lwr_en && !mwr_en) |=> $countones(regs[$past(lwr_idx)] ^ $past(regs[lwr_idx])) <= 1); // R4

   AST_LANE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      lwr_en |=> regs[$past(lwr_idx)][int'($past(lwr_tid)) % LANES] == $past(lwr_bit)); // R5

   AST_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (mwr_en && lwr_en && mwr_idx == lwr_idx) |=> $countones(regs[$past(mwr_idx)] ^ $past(mwr_data)) <= 1); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!mwr_en && !lwr_en) && $stable(mrd_idx)) |-> $stable(mrd_data)); // R9
endmodule

bind pred_rf prf_chk #(.LANES(LANES), .NREGS(NREGS), .TID_W(TID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mrd_idx(mrd_idx), .mrd_data(mrd_data),
   .mwr_en(mwr_en), .mwr_idx(mwr_idx), .mwr_data(mwr_data),
   .lwr_en(lwr_en), .lwr_idx(lwr_idx), .lwr_tid(lwr_tid), .lwr_bit(lwr_bit),
   .regs(regs)
);

// File: tb/pred_rf_tb.sv
module pred_rf_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 32;
   localparam int NREGS = 32;
   localparam int TID_W = 6;
   localparam int IDX_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [IDX_W-1:0] mrd_idx = '0, lrd_idx = '0, mwr_idx = '0, lwr_idx = '0;
   logic [TID_W-1:0] lrd_tid = '0, lwr_tid = '0;
   logic [LANES-1:0] mrd_data, mwr_data = '0;
   logic lrd_bit, mwr_en = 1'b0, lwr_en = 1'b0, lwr_bit = 1'b0;

   logic [LANES-1:0] model [NREGS];
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pred_rf #(.LANES(LANES), .NREGS(NREGS), .TID_W(TID_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .mrd_idx(mrd_idx), .mrd_data(mrd_data),
      .lrd_idx(lrd_idx), .lrd_tid(lrd_tid), .lrd_bit(lrd_bit),
      .mwr_en(mwr_en), .mwr_idx(mwr_idx), .mwr_data(mwr_data),
      .lwr_en(lwr_en), .lwr_idx(lwr_idx), .lwr_tid(lwr_tid), .lwr_bit(lwr_bit));

   task automatic chk(input string req, input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic read_mask(input int r, input string req);
      @(negedge clk); mrd_idx = IDX_W'(r); #1;
      chk(req, mrd_data, model[r]);
   endtask

   task automatic read_lane(input int r, input int t, input string req);
      @(negedge clk); lrd_idx = IDX_W'(r); lrd_tid = TID_W'(t); #1;
      chk(req, LANES'(lrd_bit), LANES'(model[r][t % LANES]));
   endtask

   task automatic mwrite(input int r, input logic [LANES-1:0] d);
      @(negedge clk); mwr_en = 1'b1; mwr_idx = IDX_W'(r); mwr_data = d;
      @(posedge clk); #1; mwr_en = 1'b0; model[r] = d;
   endtask

   task automatic lwrite(input int r, input int t, input logic b);
      @(negedge clk); lwr_en = 1'b1; lwr_idx = IDX_W'(r); lwr_tid = TID_W'(t); lwr_bit = b;
      @(posedge clk); #1; lwr_en = 1'b0; model[r][t % LANES] = b;
   endtask

   task automatic t_reset();
      for (int r = 0; r < NREGS; r++) model[r] = (r == 0) ? '1 : '0;
      @(negedge clk); mrd_idx = 0; #1; chk("R2 p0 in reset", mrd_data, '1);
      mrd_idx = 7; #1; chk("R2 p7 in reset", mrd_data, '0);
      @(negedge clk); rst_n = 1'b1;
      for (int r = 0; r < NREGS; r += 5) read_mask(r, "R2/R1 after reset");
   endtask

   task automatic t_mask_write();
      mwrite(4, 32'hDEAD_BEEF); read_mask(4, "R6 mask write");
      mwrite(31, 32'h0F0F_1234); read_mask(31, "R6 last register");
      mwrite(0, 32'h0000_0000); read_mask(0, "R6 overwrite p0");
      read_mask(5, "R1 neighbour untouched");
   endtask

   task automatic t_lane_rw();
      mwrite(9, 32'hAAAA_AAAA);
      lwrite(9, 0, 1'b1); read_mask(9, "R4 set lane 0 only");
      lwrite(9, 31, 1'b0); read_mask(9, "R4 clear lane 31 only");
      read_lane(9, 0, "R3 lane 0"); read_lane(9, 1, "R3 lane 1");
      read_lane(9, 2, "R3 lane 2"); read_lane(9, 31, "R3 lane 31");
   endtask

   task automatic t_wrap();
      lwrite(12, 33, 1'b1); read_mask(12, "R5 thread 33 sets lane 1");
      chk("R5 lane 1 value", model[12], 32'h0000_0002);
      lwrite(12, 63, 1'b1); read_mask(12, "R5 thread 63 sets lane 31");
      read_lane(12, 33, "R5 read thread 33");
      read_lane(12, 34, "R5 read thread 34");
   endtask

   task automatic t_collide();
      @(negedge clk);
      mwr_en = 1'b1; mwr_idx = 3; mwr_data = 32'h0000_0000;
      lwr_en = 1'b1; lwr_idx = 3; lwr_tid = 5; lwr_bit = 1'b1;
      @(posedge clk); #1; mwr_en = 1'b0; lwr_en = 1'b0;
      model[3] = 32'h0000_0020;
      read_mask(3, "R7 lane over mask (set)");
      @(negedge clk);
      mwr_en = 1'b1; mwr_idx = 3; mwr_data = 32'hFFFF_FFFF;
      lwr_en = 1'b1; lwr_idx = 3; lwr_tid = 2; lwr_bit = 1'b0;
      @(posedge clk); #1; mwr_en = 1'b0; lwr_en = 1'b0;
      model[3] = 32'hFFFF_FFFB;
      read_mask(3, "R7 lane over mask (clear)");
   endtask

   task automatic t_read_old();
      @(negedge clk);
      mrd_idx = 20; lrd_idx = 20; lrd_tid = 4;
      mwr_en = 1'b1; mwr_idx = 20; mwr_data = 32'h1234_5670;
      #1; chk("R8 old mask before edge", mrd_data, model[20]);
      chk("R8 old lane before edge", LANES'(lrd_bit), LANES'(model[20][4]));
      @(posedge clk); #1; mwr_en = 1'b0; model[20] = 32'h1234_5670;
      chk("R8 new mask after edge", mrd_data, model[20]);
      chk("R1 lane read after edge", LANES'(lrd_bit), LANES'(1'b1));
   endtask

   task automatic t_idle();
      @(negedge clk);
      mwr_en = 1'b0; mwr_idx = 4; mwr_data = 32'h5555_5555;
      lwr_en = 1'b0; lwr_idx = 9; lwr_tid = 3; lwr_bit = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      read_mask(4, "R9 idle mask data ignored");
      read_mask(9, "R9 idle lane data ignored");
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_mask_write();
      t_lane_rw();
      t_wrap();
      t_collide();
      t_read_old();
      t_idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule